// File: doc/BRIEF.md
# Asymmetric Decode Steering with Micro-op Queue

This block sits between a fetch buffer and rename. Each cycle the fetch buffer offers up to three macro-instructions whose lengths are already known. Each one carries a tag, a micro-op count (stored as count minus one) and a template index. The block assigns them in program order to three decode slots. The first slot is the complex one and may expand an instruction into one to four micro-ops. The two other slots accept only single micro-op instructions. An instruction that expands to more than four micro-ops goes to a microcode sequencer, which then produces the whole sequence over several cycles.

Decoded micro-ops enter a six-entry queue. Rename reads the three oldest entries and removes up to three of them per cycle. Each micro-op holds the tag and template of its parent instruction, its step number within that instruction, and a flag that marks the final micro-op of the instruction. The block tells the fetch buffer how many instructions it took this cycle, from zero to three.

Top module: `decst_top`

## Requirements
- R1: While reset is held and just after it, the queue holds zero entries, `q_valid` is all zero, `seq_busy` is low and `fb_take` is zero.
- R2: Slots are filled in program order. Lanes 1 and 2 are taken only if their length field is 0 (one micro-op). The first later lane that needs more than one micro-op ends the group, so `fb_take` counts only the lanes before it.
- R3: A lane-0 instruction with length field L ≤ 3 produces L+1 queue entries. They carry its tag and template, steps 0 to L in order, and `last` is set only on step L. Each following simple lane adds one entry with step 0 and `last` set.
- R4: A lane-0 instruction with length field L ≥ 4 is taken alone (`fb_take` = 1) and queues nothing in that cycle. From the next cycle `seq_busy` is high, and the sequencer queues steps 0 to L in order with `last` only on step L.
- R5: While `seq_busy` is high, `fb_take` is 0.
- R6: Let free be 6 minus the queue count at the start of the cycle. A decode group is taken only if its total micro-op count is at most free. Otherwise `fb_take` is 0 and nothing is queued.
- R7: The queue is first-in first-out. `rn_pop` removes min(`rn_pop`, count) of the oldest entries. `q_valid[i]` is high exactly when the count is above i, and output index 0 is the oldest entry.
- R8: `q_avail` never exceeds 6.
- R9: Each busy cycle, the sequencer queues min(3, remaining micro-ops, free) entries. `seq_busy` falls after the cycle that queues step L.
- R10: Lane i is considered only if `fb_valid` is set for lanes 0 to i. When lane 0 is invalid, `fb_take` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_valid | input | 3 | Per-lane instruction present |
| fb_tag | input | 18 | Per-lane instruction tag, 6 bits per lane |
| fb_tmpl | input | 9 | Per-lane template index, 3 bits per lane |
| fb_len | input | 12 | Per-lane micro-op count minus one, 4 bits per lane |
| fb_take | output | 2 | Number of lanes consumed this cycle |
| rn_pop | input | 2 | Entries rename removes this cycle |
| q_avail | output | 3 | Queue occupancy |
| q_valid | output | 3 | Head entry i present |
| q_tag | output | 18 | Head entry tags |
| q_tmpl | output | 9 | Head entry templates |
| q_step | output | 12 | Head entry step numbers |
| q_last | output | 3 | Head entry last-of-instruction flags |
| seq_busy | output | 1 | Microcode sequencer active |

## Verification
The bench uses the default parameters: three lanes, a six-entry queue, a four micro-op complex limit and a sequencer rate of three. With these values, a full group of 4+1+1 micro-ops fills the queue exactly. A long instruction of up to sixteen micro-ops keeps the sequencer busy for several cycles. Holding rename back early in the run fills the queue, so the all-or-nothing space rule and the sequencer stalls caused by a full queue both occur.

// File: rtl/decst_pkg.sv
package decst_pkg;
  parameter int TAG_W  = 6;
  parameter int TMPL_W = 3;
  parameter int STEP_W = 4;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [TMPL_W-1:0] tmpl;
    logic [STEP_W-1:0] step;
    logic              last;
  } uop_t;
endpackage

// File: rtl/decst_steer.sv
module decst_steer
  import decst_pkg::*;
#(
  parameter int LANES    = 3,
  parameter int CPLX_MAX = 4,
  parameter int PUSH_MAX = CPLX_MAX + LANES - 1,
  parameter int CNT_W    = 3,
  parameter int TAKE_W   = 2,
  parameter int PN_W     = 3
) (
  input  logic [LANES-1:0]              fb_valid,
  input  logic [LANES-1:0][TAG_W-1:0]   fb_tag,
  input  logic [LANES-1:0][TMPL_W-1:0]  fb_tmpl,
  input  logic [LANES-1:0][STEP_W-1:0]  fb_len,
  input  logic [CNT_W-1:0]              free,
  input  logic                          seq_busy,
  output logic [TAKE_W-1:0]             take,
  output logic [PN_W-1:0]               push_n,
  output uop_t                          push_uop [PUSH_MAX],
  output logic                          seq_start
);
  int   total;
  int   grp;
  int   lane;
  int   len0;
  logic run;

  always_comb begin
    take      = '0;
    push_n    = '0;
    seq_start = 1'b0;
    total     = 0;
    grp       = 0;
    lane      = 0;
    run       = 1'b1;
    len0      = int'(fb_len[0]);
    for (int j = 0; j < PUSH_MAX; j++) push_uop[j] = '0;
    if (!seq_busy && fb_valid[0]) begin
      if (len0 >= CPLX_MAX) begin
        seq_start = 1'b1;
        take      = TAKE_W'(1);
      end else begin
        total = len0 + 1;
        grp   = 1;
        for (int i = 1; i < LANES; i++) begin
          if (run && fb_valid[i] && (fb_len[i] == '0)) begin
            grp   = i + 1;
            total = total + 1;
          end else begin
            run = 1'b0;
          end
        end
        if (total <= int'(free)) begin
          take   = TAKE_W'(grp);
          push_n = PN_W'(total);
          for (int j = 0; j < PUSH_MAX; j++) begin
            if (j <= len0) begin
              push_uop[j].tag  = fb_tag[0];
              push_uop[j].tmpl = fb_tmpl[0];
              push_uop[j].step = STEP_W'(j);
              push_uop[j].last = (j == len0);
            end else if (j < total) begin
              lane = j - len0;
              push_uop[j].tag  = fb_tag[lane];
              push_uop[j].tmpl = fb_tmpl[lane];
              push_uop[j].step = '0;
              push_uop[j].last = 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/decst_useq.sv
module decst_useq
  import decst_pkg::*;
#(
  parameter int SEQ_RATE = 3,
  parameter int CNT_W    = 3,
  parameter int PN_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TAG_W-1:0]  st_tag,
  input  logic [TMPL_W-1:0] st_tmpl,
  input  logic [STEP_W-1:0] st_len,
  input  logic [CNT_W-1:0]  free,
  output logic              busy,
  output logic [PN_W-1:0]   emit_n,
  output uop_t              emit_uop [SEQ_RATE]
);
  logic              busy_q, busy_d;
  logic [STEP_W:0]   step_q, step_d;
  logic [TAG_W-1:0]  tag_q;
  logic [TMPL_W-1:0] tmpl_q;
  logic [STEP_W-1:0] len_q;
  int                rem;
  int                emit;

  assign busy = busy_q;

  always_comb begin
    rem  = int'(len_q) + 1 - int'(step_q);
    emit = 0;
    if (busy_q) begin
      emit = SEQ_RATE;
      if (rem < emit) emit = rem;
      if (int'(free) < emit) emit = int'(free);
    end
    emit_n = PN_W'(emit);
    for (int j = 0; j < SEQ_RATE; j++) begin
      emit_uop[j] = '0;
      if (j < emit) begin
        emit_uop[j].tag  = tag_q;
        emit_uop[j].tmpl = tmpl_q;
        emit_uop[j].step = STEP_W'(int'(step_q) + j);
        emit_uop[j].last = ((int'(step_q) + j) == int'(len_q));
      end
    end
  end

  always_comb begin
    busy_d = busy_q;
    step_d = step_q;
    if (start) begin
      busy_d = 1'b1;
      step_d = '0;
    end else if (busy_q) begin
      step_d = (STEP_W+1)'(int'(step_q) + emit);
      busy_d = (int'(step_q) + emit) <= int'(len_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
    end else begin
      busy_q <= busy_d;
      step_q <= step_d;
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      tag_q  <= st_tag;
      tmpl_q <= st_tmpl;
      len_q  <= st_len;
    end
  end
endmodule

// File: rtl/decst_uq.sv
module decst_uq
  import decst_pkg::*;
#(
  parameter int DEPTH    = 6,
  parameter int PUSH_MAX = 6,
  parameter int POP_MAX  = 3,
  parameter int CNT_W    = $clog2(DEPTH + 1),
  parameter int PN_W     = $clog2(PUSH_MAX + 1),
  parameter int POP_W    = $clog2(POP_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PN_W-1:0]  push_n,
  input  uop_t             push_uop [PUSH_MAX],
  input  logic [POP_W-1:0] pop,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] free,
  output logic [POP_MAX-1:0] head_vld,
  output uop_t             head_uop [POP_MAX]
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  uop_t             mem [DEPTH];
  logic [PTR_W-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  int               pop_eff;

  function automatic logic [PTR_W-1:0] wrap(input int a);
    return PTR_W'(a % DEPTH);
  endfunction

  always_comb begin
    pop_eff = (int'(pop) > int'(cnt_q)) ? int'(cnt_q) : int'(pop);
    rd_d    = wrap(int'(rd_q) + pop_eff);
    wr_d    = wrap(int'(wr_q) + int'(push_n));
    cnt_d   = CNT_W'(int'(cnt_q) + int'(push_n) - pop_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < PUSH_MAX; j++) begin
      if (j < int'(push_n)) mem[wrap(int'(wr_q) + j)] <= push_uop[j];
    end
  end

  assign count = cnt_q;
  assign free  = CNT_W'(DEPTH - int'(cnt_q));

  for (genvar i = 0; i < POP_MAX; i++) begin : g_head
    assign head_vld[i] = int'(cnt_q) > i;
    assign head_uop[i] = mem[wrap(int'(rd_q) + i)];
  end
endmodule

// File: rtl/decst_top.sv
module decst_top
  import decst_pkg::*;
#(
  parameter int LANES    = 3,
  parameter int DEPTH    = 6,
  parameter int CPLX_MAX = 4,
  parameter int SEQ_RATE = 3,
  localparam int PUSH_MAX = CPLX_MAX + LANES - 1,
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int TAKE_W   = $clog2(LANES + 1),
  localparam int PN_W     = $clog2(PUSH_MAX + 1),
  localparam int POP_W    = $clog2(LANES + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LANES-1:0]         fb_valid,
  input  logic [LANES*TAG_W-1:0]   fb_tag,
  input  logic [LANES*TMPL_W-1:0]  fb_tmpl,
  input  logic [LANES*STEP_W-1:0]  fb_len,
  output logic [TAKE_W-1:0]        fb_take,
  input  logic [POP_W-1:0]         rn_pop,
  output logic [CNT_W-1:0]         q_avail,
  output logic [LANES-1:0]         q_valid,
  output logic [LANES*TAG_W-1:0]   q_tag,
  output logic [LANES*TMPL_W-1:0]  q_tmpl,
  output logic [LANES*STEP_W-1:0]  q_step,
  output logic [LANES-1:0]         q_last,
  output logic                     seq_busy
);
  logic [LANES-1:0][TAG_W-1:0]  tag_a;
  logic [LANES-1:0][TMPL_W-1:0] tmpl_a;
  logic [LANES-1:0][STEP_W-1:0] len_a;
  logic [CNT_W-1:0]             free;
  logic [PN_W-1:0]              dec_n, seq_n, push_n;
  uop_t                         dec_uop  [PUSH_MAX];
  uop_t                         seq_uop  [SEQ_RATE];
  uop_t                         push_uop [PUSH_MAX];
  uop_t                         head_uop [LANES];
  logic                         seq_start;

  assign tag_a  = fb_tag;
  assign tmpl_a = fb_tmpl;
  assign len_a  = fb_len;

  decst_steer #(
    .LANES(LANES), .CPLX_MAX(CPLX_MAX), .PUSH_MAX(PUSH_MAX),
    .CNT_W(CNT_W), .TAKE_W(TAKE_W), .PN_W(PN_W)
  ) u_steer (
    .fb_valid (fb_valid),
    .fb_tag   (tag_a),
    .fb_tmpl  (tmpl_a),
    .fb_len   (len_a),
    .free     (free),
    .seq_busy (seq_busy),
    .take     (fb_take),
    .push_n   (dec_n),
    .push_uop (dec_uop),
    .seq_start(seq_start)
  );

  decst_useq #(.SEQ_RATE(SEQ_RATE), .CNT_W(CNT_W), .PN_W(PN_W)) u_useq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (seq_start),
    .st_tag  (tag_a[0]),
    .st_tmpl (tmpl_a[0]),
    .st_len  (len_a[0]),
    .free    (free),
    .busy    (seq_busy),
    .emit_n  (seq_n),
    .emit_uop(seq_uop)
  );

  assign push_n = seq_busy ? seq_n : dec_n;
  for (genvar j = 0; j < PUSH_MAX; j++) begin : g_mux
    if (j < SEQ_RATE) begin : g_both
      assign push_uop[j] = seq_busy ? seq_uop[j] : dec_uop[j];
    end else begin : g_dec
      assign push_uop[j] = seq_busy ? uop_t'('0) : dec_uop[j];
    end
  end

  decst_uq #(
    .DEPTH(DEPTH), .PUSH_MAX(PUSH_MAX), .POP_MAX(LANES),
    .CNT_W(CNT_W), .PN_W(PN_W), .POP_W(POP_W)
  ) u_uq (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_n  (push_n),
    .push_uop(push_uop),
    .pop     (rn_pop),
    .count   (q_avail),
    .free    (free),
    .head_vld(q_valid),
    .head_uop(head_uop)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_out
    assign q_tag [i*TAG_W  +: TAG_W ] = head_uop[i].tag;
    assign q_tmpl[i*TMPL_W +: TMPL_W] = head_uop[i].tmpl;
    assign q_step[i*STEP_W +: STEP_W] = head_uop[i].step;
    assign q_last[i]                  = head_uop[i].last;
  end
endmodule

// File: rtl/decst_chk.sv
module decst_chk #(
  parameter int LANES    = 3,
  parameter int DEPTH    = 6,
  parameter int SEQ_RATE = 3,
  parameter int CNT_W    = 3,
  parameter int TAKE_W   = 2,
  parameter int PN_W     = 3,
  parameter int POP_W    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LANES-1:0]  fb_valid,
  input logic [TAKE_W-1:0] fb_take,
  input logic [POP_W-1:0]  rn_pop,
  input logic [CNT_W-1:0]  q_avail,
  input logic [PN_W-1:0]   push_n,
  input logic              seq_busy
);
  logic [CNT_W-1:0] pop_eff;
  assign pop_eff = (int'(rn_pop) > int'(q_avail)) ? q_avail : CNT_W'(rn_pop);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(q_avail) <= DEPTH); // R8
  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |-> fb_take == '0); // R5
  AST_TAKE_NEEDS_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_take != '0) |-> fb_valid[0]); // R10
  AST_PUSH_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    int'(push_n) <= DEPTH - int'(q_avail)); // R6
  AST_SEQ_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |-> int'(push_n) <= SEQ_RATE); // R9
  AST_SEQ_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_busy) |-> int'($past(fb_take)) == 1); // R4
  AST_CNT_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> int'(q_avail) ==
      int'($past(q_avail)) + int'($past(push_n)) - int'($past(pop_eff))); // R7
endmodule

bind decst_top decst_chk #(
  .LANES(LANES), .DEPTH(DEPTH), .SEQ_RATE(SEQ_RATE), .CNT_W(CNT_W),
  .TAKE_W(TAKE_W), .PN_W(PN_W), .POP_W(POP_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .fb_valid(fb_valid),
  .fb_take (fb_take),
  .rn_pop  (rn_pop),
  .q_avail (q_avail),
  .push_n  (push_n),
  .seq_busy(seq_busy)
);

// File: tb/decst_top_bench.sv
module decst_top_bench;
  import decst_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 3;
  localparam int DEPTH = 6;
  localparam int NPROG = 400;
  localparam int LIMIT = 6000;

  typedef struct {
    int tag;
    int tmpl;
    int step;
    int last;
  } mu_t;

  logic clk, rst_n;
  logic [LANES-1:0]        fb_valid;
  logic [LANES*TAG_W-1:0]  fb_tag;
  logic [LANES*TMPL_W-1:0] fb_tmpl;
  logic [LANES*STEP_W-1:0] fb_len;
  logic [1:0]              fb_take;
  logic [1:0]              rn_pop;
  logic [2:0]              q_avail;
  logic [LANES-1:0]        q_valid;
  logic [LANES*TAG_W-1:0]  q_tag;
  logic [LANES*TMPL_W-1:0] q_tmpl;
  logic [LANES*STEP_W-1:0] q_step;
  logic [LANES-1:0]        q_last;
  logic                    seq_busy;

  decst_top u_decst_top (
    .clk(clk), .rst_n(rst_n), .fb_valid(fb_valid), .fb_tag(fb_tag),
    .fb_tmpl(fb_tmpl), .fb_len(fb_len), .fb_take(fb_take), .rn_pop(rn_pop),
    .q_avail(q_avail), .q_valid(q_valid), .q_tag(q_tag), .q_tmpl(q_tmpl),
    .q_step(q_step), .q_last(q_last), .seq_busy(seq_busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int p_len [NPROG];
  int p_tmpl[NPROG];
  mu_t mq[$];
  int  mbusy = 0, mrem = 0, mstep = 0, mlen = 0, mtag = 0, mtmpl = 0;
  bit  prev_busy = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cmp_state();
    string rq;
    rq = prev_busy ? "R9" : "R7";
    chk(int'(q_avail) == mq.size(), rq, "q_avail", int'(q_avail), mq.size());
    chk(int'(q_avail) <= DEPTH, "R8", "q_avail bound", int'(q_avail), DEPTH);
    chk(seq_busy == (mbusy != 0), "R4", "seq_busy", int'(seq_busy), mbusy);
    for (int i = 0; i < LANES; i++) begin
      chk(q_valid[i] == (i < mq.size()), "R7", "q_valid", int'(q_valid[i]),
          int'(i < mq.size()));
      if (i < mq.size()) begin
        chk(int'(q_tag[i*TAG_W +: TAG_W]) == mq[i].tag, "R3 R4", "tag",
            int'(q_tag[i*TAG_W +: TAG_W]), mq[i].tag);
        chk(int'(q_tmpl[i*TMPL_W +: TMPL_W]) == mq[i].tmpl, "R3 R4", "tmpl",
            int'(q_tmpl[i*TMPL_W +: TMPL_W]), mq[i].tmpl);
        chk(int'(q_step[i*STEP_W +: STEP_W]) == mq[i].step, "R3 R4", "step",
            int'(q_step[i*STEP_W +: STEP_W]), mq[i].step);
        chk(int'(q_last[i]) == mq[i].last, "R3 R4", "last",
            int'(q_last[i]), mq[i].last);
      end
    end
  endtask

  initial begin : main
    int ptr, cyc, nv, free, take, tot, pops, e, len0;
    bit gap;
    string cat;
    mu_t u;
    for (int i = 0; i < NPROG; i++) begin
      int r;
      r = int'($urandom % 100);
      p_len[i]  = (r < 60) ? 0 : (r < 85) ? 1 + int'($urandom % 3) : 4 + int'($urandom % 12);
      p_tmpl[i] = int'($urandom % 8);
    end
    // directed opening: full simple group, complex+simple, multi in lane 1, long
    p_len[0] = 0; p_len[1] = 0; p_len[2] = 0;
    p_len[3] = 3; p_len[4] = 0; p_len[5] = 0;
    p_len[6] = 0; p_len[7] = 2; p_len[8] = 0;
    p_len[9] = 15; p_len[10] = 4; p_len[11] = 0;

    rst_n = 1'b0; fb_valid = '0; fb_tag = '0; fb_tmpl = '0; fb_len = '0; rn_pop = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state while reset is asserted
    chk(q_avail == '0, "R1", "q_avail in reset", int'(q_avail), 0);
    chk(q_valid == '0, "R1", "q_valid in reset", int'(q_valid), 0);
    chk(seq_busy == 1'b0, "R1", "seq_busy in reset", int'(seq_busy), 0);
    chk(fb_take == '0, "R1", "fb_take in reset", int'(fb_take), 0);
    rst_n = 1'b1;

    ptr = 0; cyc = 0;
    while (cyc < LIMIT && !(ptr == NPROG && mq.size() == 0 && mbusy == 0)) begin
      cmp_state();
      // drive inputs
      fb_valid = '0;
      for (int i = 0; i < LANES; i++) begin
        fb_tag [i*TAG_W  +: TAG_W ] = TAG_W'($urandom);
        fb_tmpl[i*TMPL_W +: TMPL_W] = TMPL_W'($urandom);
        fb_len [i*STEP_W +: STEP_W] = STEP_W'($urandom);
        if (ptr + i < NPROG) begin
          fb_valid[i] = 1'b1;
          fb_tag [i*TAG_W  +: TAG_W ] = TAG_W'((ptr + i) % 64);
          fb_tmpl[i*TMPL_W +: TMPL_W] = TMPL_W'(p_tmpl[ptr + i]);
          fb_len [i*STEP_W +: STEP_W] = STEP_W'(p_len[ptr + i]);
        end
      end
      gap = 0;
      if (cyc > 5 && ($urandom % 8) == 0) begin
        fb_valid = fb_valid & LANES'($urandom);
        gap = 1;
      end
      rn_pop = (cyc < 40) ? 2'd0 : 2'($urandom);
      nv = 0;
      for (int i = 0; i < LANES; i++) if (fb_valid[i] && nv == i) nv = i + 1;
      #1;
      // reference decision
      free = DEPTH - mq.size();
      take = 0; tot = 0; cat = "R2";
      len0 = (nv > 0) ? p_len[ptr] : 0;
      if (mbusy != 0) cat = "R5";
      else if (nv == 0) cat = "R10";
      else if (len0 >= 4) begin take = 1; cat = "R4"; end
      else begin
        int k;
        k = 1; tot = len0 + 1;
        if (nv > 1 && p_len[ptr+1] == 0) begin
          k = 2; tot++;
          if (nv > 2 && p_len[ptr+2] == 0) begin k = 3; tot++; end
        end
        if (gap) cat = "R10";
        if (tot <= free) take = k;
        else begin take = 0; cat = "R6"; end
      end
      chk(int'(fb_take) == take, cat, "fb_take", int'(fb_take), take);
      // reference update: pops leave older entries first
      pops = (int'(rn_pop) > mq.size()) ? mq.size() : int'(rn_pop);
      for (int i = 0; i < pops; i++) void'(mq.pop_front());
      prev_busy = (mbusy != 0);
      if (mbusy != 0) begin
        e = 3; if (mrem < e) e = mrem; if (free < e) e = free;
        for (int j = 0; j < e; j++) begin
          u.tag = mtag; u.tmpl = mtmpl; u.step = mstep; u.last = int'(mstep == mlen);
          mq.push_back(u); mstep++;
        end
        mrem -= e;
        if (mrem == 0) mbusy = 0;
      end else if (take == 1 && len0 >= 4) begin
        mbusy = 1; mrem = len0 + 1; mstep = 0; mlen = len0;
        mtag = ptr % 64; mtmpl = p_tmpl[ptr];
      end else if (take > 0) begin
        for (int j = 0; j <= len0; j++) begin
          u.tag = ptr % 64; u.tmpl = p_tmpl[ptr]; u.step = j; u.last = int'(j == len0);
          mq.push_back(u);
        end
        for (int i = 1; i < take; i++) begin
          u.tag = (ptr + i) % 64; u.tmpl = p_tmpl[ptr + i]; u.step = 0; u.last = 1;
          mq.push_back(u);
        end
      end
      ptr += take;
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
    cmp_state();
    if (cyc >= LIMIT) begin
      checks++; fails++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", cyc, LIMIT);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule